// File: doc/BRIEF.md
# UART Receive FIFO and Register Interface

This block is the register side of a UART. On one side it takes bytes from a serial receive core through a valid/ready handshake and queues them in a receive FIFO. On the other side it presents a word-addressed host bus: a data register, a flag register, interrupt mask, raw and masked status, and an interrupt clear. It also holds plain storage for the divisor, line-control, control, level-select and DMA-control registers. Writing the data register hands one byte to the transmit side and raises the transmit interrupt. A read-only table of eight identification bytes occupies the top eight words of the address window.

A line-control bit chooses the receive capacity: the full 16-entry FIFO, or a single holding slot. Occupancy is tracked by a three-state fill machine. EMPTY goes to PARTIAL on a push that leaves the count below capacity, and goes to FULL on a push that reaches it. PARTIAL goes to FULL when the count reaches capacity, and goes to EMPTY when a pop takes the last entry. FULL goes to PARTIAL or EMPTY on a pop. Any state goes to FULL when the capacity shrinks to the current count or below. The receive interrupt follows the fill level against a trigger of one entry. It sets when a push brings the count up to the trigger, and it clears when a pop brings the count down to one below it.

Top module: `uart_rx_regif`

## Requirements
- R1: After reset the flag register reads 0x90, level select reads 0x12, control reads 0x300, and every other storage register, the mask and the raw status read 0. `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Word offsets are: data 0, flags 6, low-power divisor 8, integer divisor 9, fractional divisor 10, line control 11, control 12, level select 13, mask 14, raw status 15, masked status 16, interrupt clear 17, DMA control 18. The bus byte address is four times the word offset. Each storage register reads back the low 16 bits last written.
- R3: With line-control bit 4 set the FIFO holds 16 bytes, otherwise 1. `rx_ready` is low exactly when the count equals the selected capacity. A byte offered while `rx_ready` is low is dropped. Bytes read from the data register come out in arrival order, in bits 7:0.
- R4: Flag bit 4 is receive-empty (count 0), bit 6 is receive-full (count 16), bit 7 (transmit-empty) reads 1 and bit 5 (transmit-full) reads 0.
- R5: Reading the data register while the FIFO is empty returns the byte in the slot at the read pointer. The pointer and count do not change.
- R6: Raw status bit 4 (receive) sets when a push alone brings the count to 1, and clears when a pop alone brings the count to 0.
- R7: A write to the data register drives `tx_valid` high in that cycle with `tx_byte` equal to write data bits 7:0. It sets raw status bit 5 (transmit).
- R8: Writing the interrupt-clear register clears each raw bit (5 and 4) written as 1. A set event in the same cycle wins over the clear.
- R9: Masked status equals raw status ANDed with mask bits 5:4. `irq` is high when any masked bit is set.
- R10: Byte addresses 0xFE0 to 0xFFC read, in address order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a data-register read pops at the clock edge |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rx_valid | input | 1 | Received byte offered by the serial core |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_valid | output | 1 | Byte for the transmitter, high during a data write |
| tx_byte | output | 8 | Byte for the transmitter |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are never high in the same cycle. This keeps a transmit write from coinciding with a data-register pop. They also assume the address is stable while a strobe is high. The stimulus issues one bus access at a time and changes inputs a time unit after a clock edge. Receive pushes may overlap a bus write, but only where the design gives a defined priority (set over clear). Some bytes are offered while `rx_ready` is low, on purpose, to check that they are dropped.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    // word offsets
    localparam int OFS_DATA = 0;
    localparam int OFS_FLAG = 6;
    localparam int OFS_LPDV = 8;
    localparam int OFS_IDIV = 9;
    localparam int OFS_FDIV = 10;
    localparam int OFS_LINE = 11;
    localparam int OFS_CTRL = 12;
    localparam int OFS_LVLS = 13;
    localparam int OFS_MASK = 14;
    localparam int OFS_RAW  = 15;
    localparam int OFS_MSKD = 16;
    localparam int OFS_ICLR = 17;
    localparam int OFS_DMAC = 18;

    localparam int LINE_FIFO_BIT = 4;
    localparam logic [15:0] CTRL_RST = 16'h0300;
    localparam logic [15:0] LVLS_RST = 16'h0012;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_e;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h11;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic          fifo_on_nxt,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          can_accept,
    output logic          pushed,
    output logic          popped
);
    fill_e            state, state_nxt;
    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_nxt, cap_nxt;
    logic             has_data;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // output decode of the fill state
    always_comb begin
        can_accept = 1'b0;
        has_data   = 1'b0;
        unique case (state)
            FILL_EMPTY: can_accept = 1'b1;
            FILL_PART: begin
                can_accept = 1'b1;
                has_data   = 1'b1;
            end
            FILL_FULL: has_data = 1'b1;
            default: ;
        endcase
    end

    assign pushed  = push_req && can_accept;
    assign popped  = pop_req && has_data;
    assign cnt_nxt = count + CW'(pushed) - CW'(popped);
    assign cap_nxt = fifo_on_nxt ? CW'(DEPTH) : CW'(1);
    assign head    = mem[rd_ptr];

    always_comb begin
        if (cnt_nxt == '0)
            state_nxt = FILL_EMPTY;
        else if (cnt_nxt >= cap_nxt)
            state_nxt = FILL_FULL;
        else
            state_nxt = FILL_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FILL_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            if (pushed) wr_ptr <= bump(wr_ptr);
            if (popped) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (pushed) begin
            mem[wr_ptr] <= push_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_FULL) |-> (count >= (fifo_on ? CW'(DEPTH) : CW'(1)))); // R3
    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (popped && !pushed) |=> (count == $past(count) - CW'(1))); // R3
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && count == '0) |=> (count == '0 && $stable(rd_ptr))); // R5
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_set,
    input  logic       rx_clr,
    input  logic       tx_set,
    input  logic       iclr_we,
    input  logic [1:0] iclr_bits,   // [1]=transmit, [0]=receive
    input  logic       mask_we,
    input  logic [1:0] mask_wdata,
    output logic [1:0] raw,
    output logic [1:0] mask,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            if (rx_set)
                raw[0] <= 1'b1;
            else if (rx_clr || (iclr_we && iclr_bits[0]))
                raw[0] <= 1'b0;
            if (tx_set)
                raw[1] <= 1'b1;
            else if (iclr_we && iclr_bits[1])
                raw[1] <= 1'b0;
            if (mask_we)
                mask <= mask_wdata;
        end
    end

    assign irq = |(raw & mask);

    AST_RX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> raw[0]); // R6
    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_set) |=> !raw[0]); // R6
    AST_TX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> raw[1]); // R7
    AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr_we && iclr_bits[1] && !tx_set) |=> !raw[1]); // R8
endmodule

// File: rtl/uart_rx_regif.sv
module uart_rx_regif
    import uart_rx_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int BUS_W   = 32,
    parameter int REG_W   = 16,
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 1,
    localparam int WW     = ADDR_W - 2,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    logic [WW-1:0]    word;
    logic             id_hit, data_sel;
    logic [REG_W-1:0] lpdv_q, idiv_q, fdiv_q, line_q, ctrl_q, lvls_q, dmac_q;
    logic             fifo_on_nxt, pop_req, pushed, popped;
    logic [7:0]       head;
    logic [CW-1:0]    count;
    logic             rx_set, rx_clr;
    logic [1:0]       raw, mask;
    logic [7:0]       flags;

    assign word     = bus_addr[ADDR_W-1:2];
    assign id_hit   = &word[WW-1:3];
    assign data_sel = !id_hit && (int'(word) == OFS_DATA);
    assign pop_req  = bus_rd && data_sel;
    assign tx_valid = bus_wr && data_sel;
    assign tx_byte  = bus_wdata[7:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpdv_q <= '0;
            idiv_q <= '0;
            fdiv_q <= '0;
            line_q <= '0;
            ctrl_q <= REG_W'(CTRL_RST);
            lvls_q <= REG_W'(LVLS_RST);
            dmac_q <= '0;
        end else if (bus_wr && !id_hit) begin
            case (int'(word))
                OFS_LPDV: lpdv_q <= bus_wdata[REG_W-1:0];
                OFS_IDIV: idiv_q <= bus_wdata[REG_W-1:0];
                OFS_FDIV: fdiv_q <= bus_wdata[REG_W-1:0];
                OFS_LINE: line_q <= bus_wdata[REG_W-1:0];
                OFS_CTRL: ctrl_q <= bus_wdata[REG_W-1:0];
                OFS_LVLS: lvls_q <= bus_wdata[REG_W-1:0];
                OFS_DMAC: dmac_q <= bus_wdata[REG_W-1:0];
                default: ;
            endcase
        end
    end

    assign fifo_on_nxt = (bus_wr && !id_hit && int'(word) == OFS_LINE)
                       ? bus_wdata[LINE_FIFO_BIT] : line_q[LINE_FIFO_BIT];

    uart_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_on    (line_q[LINE_FIFO_BIT]),
        .fifo_on_nxt(fifo_on_nxt),
        .push_req   (rx_valid),
        .push_data  (rx_byte),
        .pop_req    (pop_req),
        .head       (head),
        .count      (count),
        .can_accept (rx_ready),
        .pushed     (pushed),
        .popped     (popped)
    );

    assign rx_set = pushed && !popped && (count == CW'(RX_TRIG - 1));
    assign rx_clr = popped && !pushed && (count == CW'(RX_TRIG));

    uart_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_set    (rx_set),
        .rx_clr    (rx_clr),
        .tx_set    (tx_valid),
        .iclr_we   (bus_wr && !id_hit && int'(word) == OFS_ICLR),
        .iclr_bits (bus_wdata[5:4]),
        .mask_we   (bus_wr && !id_hit && int'(word) == OFS_MASK),
        .mask_wdata(bus_wdata[5:4]),
        .raw       (raw),
        .mask      (mask),
        .irq       (irq)
    );

    // bit7 tx empty, bit6 rx full, bit5 tx full, bit4 rx empty
    assign flags = {1'b1, count == CW'(DEPTH), 1'b0, count == '0, 4'b0};

    always_comb begin
        bus_rdata = '0;
        if (id_hit) begin
            bus_rdata = BUS_W'(ident_byte(word[2:0]));
        end else begin
            case (int'(word))
                OFS_DATA: bus_rdata = BUS_W'(head);
                OFS_FLAG: bus_rdata = BUS_W'(flags);
                OFS_LPDV: bus_rdata = BUS_W'(lpdv_q);
                OFS_IDIV: bus_rdata = BUS_W'(idiv_q);
                OFS_FDIV: bus_rdata = BUS_W'(fdiv_q);
                OFS_LINE: bus_rdata = BUS_W'(line_q);
                OFS_CTRL: bus_rdata = BUS_W'(ctrl_q);
                OFS_LVLS: bus_rdata = BUS_W'(lvls_q);
                OFS_MASK: bus_rdata = BUS_W'({mask, 4'b0});
                OFS_RAW:  bus_rdata = BUS_W'({raw, 4'b0});
                OFS_MSKD: bus_rdata = BUS_W'({raw & mask, 4'b0});
                OFS_DMAC: bus_rdata = BUS_W'(dmac_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_q[LINE_FIFO_BIT] && count != '0) |-> !rx_ready); // R3
    AST_EMPTY_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (popped && !pushed && $past(1'b1) && count == CW'(1)) |=> flags[4]); // R4
endmodule

// File: tb/tb_uart_rx_regif.sv
module tb_uart_rx_regif;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PU = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;   // write data, pushed byte, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, 12'h018, 32'h90,   4'd1},  // R1 flags
        '{OP_RD, 12'h034, 32'h12,   4'd1},  // R1 level select
        '{OP_RD, 12'h030, 32'h300,  4'd1},  // R1 control
        '{OP_RD, 12'h03C, 32'h0,    4'd1},  // R1 raw
        '{OP_RD, 12'h038, 32'h0,    4'd1},  // R1 mask
        '{OP_WR, 12'h024, 32'h1234, 4'd2},  // R2
        '{OP_RD, 12'h024, 32'h1234, 4'd2},
        '{OP_WR, 12'h048, 32'h3,    4'd2},
        '{OP_RD, 12'h048, 32'h3,    4'd2},
        '{OP_WR, 12'h020, 32'hAB,   4'd2},
        '{OP_RD, 12'h020, 32'hAB,   4'd2},
        '{OP_PU, 12'h000, 32'hA5,   4'd3},  // R3 single slot
        '{OP_RD, 12'h018, 32'h80,   4'd4},  // R4
        '{OP_RD, 12'h03C, 32'h10,   4'd6},  // R6
        '{OP_PU, 12'h000, 32'h5A,   4'd3},  // R3 dropped
        '{OP_RD, 12'h000, 32'hA5,   4'd3},
        '{OP_RD, 12'h018, 32'h90,   4'd4},
        '{OP_RD, 12'h03C, 32'h0,    4'd6},
        '{OP_RD, 12'h000, 32'h0,    4'd5},  // R5 empty read, slot 1
        '{OP_RD, 12'h018, 32'h90,   4'd5},
        '{OP_WR, 12'h02C, 32'h10,   4'd3},  // FIFO on
        '{OP_RD, 12'h02C, 32'h10,   4'd2},
        '{OP_PU, 12'h000, 32'h01,   4'd3},
        '{OP_PU, 12'h000, 32'h02,   4'd3},
        '{OP_PU, 12'h000, 32'h03,   4'd3},
        '{OP_RD, 12'h018, 32'h80,   4'd4},
        '{OP_RD, 12'h03C, 32'h10,   4'd6},
        '{OP_RD, 12'h000, 32'h01,   4'd3},
        '{OP_RD, 12'h000, 32'h02,   4'd3},
        '{OP_RD, 12'h03C, 32'h10,   4'd6},
        '{OP_RD, 12'h000, 32'h03,   4'd3},
        '{OP_RD, 12'h03C, 32'h0,    4'd6},
        '{OP_WR, 12'h038, 32'h30,   4'd9},  // R9
        '{OP_WR, 12'h000, 32'h41,   4'd7},  // R7
        '{OP_RD, 12'h03C, 32'h20,   4'd7},
        '{OP_RD, 12'h040, 32'h20,   4'd9},
        '{OP_WR, 12'h044, 32'h20,   4'd8},  // R8
        '{OP_RD, 12'h03C, 32'h0,    4'd8},
        '{OP_RD, 12'hFE0, 32'h11,   4'd10}, // R10
        '{OP_RD, 12'hFEC, 32'h00,   4'd10},
        '{OP_RD, 12'hFF4, 32'hF0,   4'd10},
        '{OP_RD, 12'hFF8, 32'h05,   4'd10},
        '{OP_RD, 12'hFFC, 32'hB1,   4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d,
                         output logic tv, output logic [7:0] tb);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1; tv = tx_valid; tb = tx_byte;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1; d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        tv;
        logic [7:0]  tb;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 rx_ready", 32'(rx_ready), 32'd1);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 tx_valid", 32'(tx_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_WR: do_wr(VECS[i].addr, VECS[i].data, tv, tb);
                OP_PU: do_push(VECS[i].data[7:0]);
                default: begin
                    do_rd(VECS[i].addr, rd);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].data);
                end
            endcase
        end

        // R3 fill all 16 slots, check stall, drop, order across pointer wrap
        for (int i = 0; i < 16; i++) do_push(8'h30 + 8'(i));
        #1;
        check("R3 rx_ready at 16", 32'(rx_ready), 32'd0);
        do_rd(12'h018, rd);
        check("R4 flags full", rd, 32'hC0);
        do_push(8'hEE);
        for (int i = 0; i < 16; i++) begin
            do_rd(12'h000, rd);
            check("R3 drain order", rd, 32'h30 + 32'(i));
        end
        #1;
        check("R3 rx_ready after drain", 32'(rx_ready), 32'd1);
        do_rd(12'h018, rd);
        check("R4 flags drained", rd, 32'h90);

        // R7 transmit hand-off and R9 irq with mask 0x30
        do_wr(12'h000, 32'hFF7E, tv, tb);
        check("R7 tx_valid", 32'(tv), 32'd1);
        check("R7 tx_byte", 32'(tb), 32'h7E);
        #1;
        check("R9 irq high", 32'(irq), 32'd1);
        do_wr(12'h044, 32'h30, tv, tb);
        #1;
        check("R8 irq after clear", 32'(irq), 32'd0);
        check("R7 no tx on clear write", 32'(tv), 32'd0);

        // R9 masked off: raw set, irq low
        do_wr(12'h038, 32'h0, tv, tb);
        do_wr(12'h000, 32'h12, tv, tb);
        #1;
        check("R9 irq masked", 32'(irq), 32'd0);
        do_rd(12'h03C, rd);
        check("R9 raw tx", rd, 32'h20);
        do_rd(12'h040, rd);
        check("R9 masked status", rd, 32'h0);
        do_wr(12'h044, 32'h20, tv, tb);

        // R8 receive set in the same cycle as a receive clear write
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h99;
        bus_wr = 1'b1; bus_addr = 12'h044; bus_wdata = 32'h10;
        @(posedge clk); #1;
        rx_valid = 1'b0; bus_wr = 1'b0;
        do_rd(12'h03C, rd);
        check("R8 set beats clear", rd, 32'h10);
        do_rd(12'h000, rd);
        check("R6 byte 0x99", rd, 32'h99);
        do_rd(12'h03C, rd);
        check("R6 cleared on last pop", rd, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule